// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block sits between the serial data lines of a UART and an infrared transceiver. On the transmit side it converts each NRZ bit into a return-to-zero light pulse. A zero bit, which includes the start bit, produces one short active-high pulse on the optical output. A one bit, which includes the stop bit, produces no pulse. On the receive side it turns the active-low pulses from the optical receiver back into NRZ levels that an ordinary UART receiver can sample.

Bit timing comes from the UART's 16x oversampling enable, `tick16`. Two timing modes are available. In the normal mode the pulse is a fixed fraction of the bit period. In the low-power mode the pulse width and the receive glitch filter are both measured in periods of a programmable prescaler clock, set by `psc` in units of core clock cycles. When `sir_en` is low, the block is transparent: the UART drives the optical output directly, and the optical input drives the UART receive line directly. The link is half duplex. The 10 ms turnaround between sending and receiving is left to the software that drives the UART.

Top module: `irda_sir_codec`

## Requirements
- R1: With `sir_en` low, `ir_out` equals `uart_tx` and `uart_rx` equals `ir_in` in the same cycle.
- R2: After reset, with `sir_en` high, `ir_out` is low (no pulse) and `uart_rx` is high (idle).
- R3: In normal mode (`lp_mode`=0), a bit starts when a change on `uart_tx` is sampled, and again every 16 `tick16` pulses after that. A zero bit sets `ir_out` high from its bit start until the third following `tick16`, which is 3/16 of the bit. A one bit leaves `ir_out` low.
- R4: Back-to-back zero bits each produce their own pulse of the same width, with one pulse per 16-tick bit period.
- R5: In low-power mode (`lp_mode`=1), a zero bit gives an `ir_out` pulse of exactly 3×`psc` clock cycles, counted from the bit start.
- R6: In low-power mode with `psc`=0, `ir_out` stays low for every bit.
- R7: In normal mode, any low seen on `ir_in` after the SYNC_STAGES-flop synchronizer drives `uart_rx` low. `uart_rx` stays low until the 17th `tick16` after the last accepted low sample. As a result, zero bits sent back to back decode as one unbroken low.
- R8: In low-power mode, a low on `ir_in` shorter than `psc` clock cycles leaves `uart_rx` high.
- R9: In low-power mode, a low on `ir_in` lasting more than 2×`psc` clock cycles is accepted and drives `uart_rx` low.
- R10: In low-power mode with `psc`=0, no low on `ir_in` is accepted, and `uart_rx` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sir_en | input | 1 | 1 selects the encoded and decoded paths, 0 selects transparent bypass |
| lp_mode | input | 1 | 0 selects normal timing, 1 selects low-power prescaler timing |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| psc | input | PSC_W | Low-power clock period in core cycles (0 is invalid) |
| uart_tx | input | 1 | NRZ transmit data from the UART |
| ir_in | input | 1 | Active-low pulses from the optical receiver |
| ir_out | output | 1 | Active-high pulses to the optical transmitter |
| uart_rx | output | 1 | Decoded NRZ data to the UART receiver |

## Verification
The bench measures the pulse width of every bit in a mixed pattern. A design that miscounts ticks, or that restarts its phase only on data edges, would give wrong widths or drop the pulse of the second zero in a run of zeros. In low-power mode the bench checks the 3×psc width, and it checks that psc=0 keeps the output dark. A divider that is not restarted at the bit start would give a shorter pulse. On the receive side the bench feeds two zero bits back to back and looks for any high gap between them, which a hold that ends too early would produce. It then sends a sub-prescaler glitch, which a missing filter would pass through, and a long valid low, which an over-strict filter would reject. Widths between one and two prescaler periods are left unchecked.

// File: rtl/irda_pkg.sv
package irda_pkg;
   typedef enum logic {
      IR_MODE_NORMAL = 1'b0,
      IR_MODE_LOWPWR = 1'b1
   } ir_mode_e;
endpackage

// File: rtl/irda_lp_divider.sv
// Low-power clock enable: one pulse every psc core cycles, restartable.
module irda_lp_divider #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PSC_W-1:0] psc,
   output logic             lp_tick
);
   logic [PSC_W-1:0] cnt;
   logic             hit;

   assign hit     = (psc != '0) && (cnt == psc - 1'b1);
   assign lp_tick = hit && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart || hit) cnt <= '0;
      else if (psc != '0)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/irda_sir_encoder.sv
// Return-to-zero pulse shaper for the transmit direction.
module irda_sir_encoder
   import irda_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int PULSE_TICKS = 3,
   parameter int PSC_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ir_mode_e         mode,
   input  logic             tick16,
   input  logic [PSC_W-1:0] psc,
   input  logic             uart_tx,
   output logic             pulse_on
);
   localparam int PH_W = $clog2(OVS);
   localparam int PC_W = $clog2(PULSE_TICKS + 1);

   initial begin
      assert (OVS >= 4 && (1 << PH_W) == OVS) else $error("OVS must be a power of two >= 4");
      assert (PULSE_TICKS >= 1 && PULSE_TICKS < OVS) else $error("PULSE_TICKS out of range");
   end

   logic            tx_q;
   logic [PH_W-1:0] phase;
   logic [PC_W-1:0] pulse_cnt;
   logic            edge_seen, bit_start, start_pulse, lp_tick, step;
   logic            lp;

   assign lp          = (mode == IR_MODE_LOWPWR);
   assign edge_seen   = uart_tx ^ tx_q;
   assign bit_start   = edge_seen || (tick16 && phase == PH_W'(OVS - 1));
   assign start_pulse = bit_start && !uart_tx && (!lp || psc != '0);
   assign step        = lp ? lp_tick : tick16;
   assign pulse_on    = (pulse_cnt != '0);

   irda_lp_divider #(.PSC_W(PSC_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_pulse),
      .psc     (psc),
      .lp_tick (lp_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q      <= 1'b1;
         phase     <= '0;
         pulse_cnt <= '0;
      end else begin
         tx_q <= uart_tx;
         if (edge_seen)   phase <= '0;
         else if (tick16) phase <= phase + 1'b1;
         if (start_pulse)                    pulse_cnt <= PC_W'(PULSE_TICKS);
         else if (step && pulse_cnt != '0)   pulse_cnt <= pulse_cnt - 1'b1;
      end
   end

   // R3
   pulse_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_on) |-> $past(!uart_tx));
   // R5
   pulse_ends_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_on) |-> $past(step));
   // R6
   lp_zero_psc_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp && psc == '0 && !pulse_on) |=> !pulse_on);
endmodule

// File: rtl/irda_sir_decoder.sv
// Pulse-to-NRZ converter for the receive direction, with low-power glitch filter.
module irda_sir_decoder
   import irda_pkg::*;
#(
   parameter int HOLD_TICKS  = 17,
   parameter int PSC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ir_mode_e         mode,
   input  logic             tick16,
   input  logic [PSC_W-1:0] psc,
   input  logic             ir_in,
   output logic             rx_out
);
   localparam int LC_W = PSC_W + 1;
   localparam int HC_W = $clog2(HOLD_TICKS + 1);

   initial begin
      assert (HOLD_TICKS >= 2) else $error("HOLD_TICKS too small");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   logic            line;
   logic            line_low, accept, lp;
   logic [LC_W-1:0] low_cnt;
   logic [LC_W-1:0] thresh;
   logic [HC_W-1:0] hold_cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line = ir_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sreg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sreg <= '1;
            else        sreg <= {sreg[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], ir_in} >> 0;
         end
         assign line = sreg[SYNC_STAGES-1];
      end
   endgenerate

   assign lp       = (mode == IR_MODE_LOWPWR);
   assign line_low = !line;
   assign thresh   = {psc, 1'b0};
   assign accept   = line_low && (!lp || (psc != '0 && low_cnt >= thresh));
   assign rx_out   = (hold_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         hold_cnt <= '0;
      end else begin
         if (!line_low)           low_cnt <= '0;
         else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
         if (accept)                         hold_cnt <= HC_W'(HOLD_TICKS);
         else if (tick16 && hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
      end
   end

   // R7
   rx_fall_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_out) |-> $past(line_low));
   // R7
   rx_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_out) |-> $past(tick16));
   // R10
   lp_zero_psc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rx_out) && $past(lp)) |-> ($past(psc) != '0));
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
   import irda_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int PULSE_TICKS = 3,
   parameter int HOLD_TICKS  = OVERSAMPLE + 1,
   parameter int PSC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sir_en,
   input  logic             lp_mode,
   input  logic             tick16,
   input  logic [PSC_W-1:0] psc,
   input  logic             uart_tx,
   input  logic             ir_in,
   output logic             ir_out,
   output logic             uart_rx
);
   ir_mode_e mode;
   logic     enc_pulse, dec_rx;

   assign mode = ir_mode_e'(lp_mode);

   irda_sir_encoder #(
      .OVS(OVERSAMPLE), .PULSE_TICKS(PULSE_TICKS), .PSC_W(PSC_W)
   ) u_enc (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tick16(tick16),
      .psc(psc), .uart_tx(uart_tx), .pulse_on(enc_pulse)
   );

   irda_sir_decoder #(
      .HOLD_TICKS(HOLD_TICKS), .PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tick16(tick16),
      .psc(psc), .ir_in(ir_in), .rx_out(dec_rx)
   );

   assign ir_out  = sir_en ? enc_pulse : uart_tx;
   assign uart_rx = sir_en ? dec_rx    : ir_in;
endmodule

// File: tb/irda_sir_codec_test.sv
module irda_sir_codec_test;
   localparam int TP  = 4;        // clocks per tick16
   localparam int BIT = 16 * TP;  // clocks per bit

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sir_en = 1'b1, lp_mode = 1'b0, uart_tx = 1'b1, ir_in = 1'b1;
   logic [7:0] psc = 8'd0;
   logic [1:0] tcnt = 2'd1;
   logic       tick16;
   logic       ir_out, uart_rx;
   int         checks = 0, fails = 0;
   bit         done = 0;

   always #10 clk = ~clk;
   always @(negedge clk) tcnt <= tcnt + 1'b1;
   assign tick16 = (tcnt == 2'd0);

   irda_sir_codec uut (
      .clk(clk), .rst_n(rst_n), .sir_en(sir_en), .lp_mode(lp_mode),
      .tick16(tick16), .psc(psc), .uart_tx(uart_tx), .ir_in(ir_in),
      .ir_out(ir_out), .uart_rx(uart_rx)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic align();
      step();
      while (!tick16) step();
   endtask

   task automatic send_bit(input logic b, output int highs);
      uart_tx = b;
      highs = 0;
      for (int i = 0; i < BIT; i++) begin
         step();
         if (ir_out) highs++;
      end
   endtask

   task automatic t_reset();
      check(ir_out == 1'b0, "R2 ir_out", ir_out, 0);
      check(uart_rx == 1'b1, "R2 uart_rx", uart_rx, 1);
   endtask

   task automatic t_bypass();
      sir_en = 1'b0;
      uart_tx = 1'b0; ir_in = 1'b1; #1;
      check(ir_out == 1'b0, "R1 tx low", ir_out, 0);
      check(uart_rx == 1'b1, "R1 rx high", uart_rx, 1);
      uart_tx = 1'b1; ir_in = 1'b0; #1;
      check(ir_out == 1'b1, "R1 tx high", ir_out, 1);
      check(uart_rx == 1'b0, "R1 rx low", uart_rx, 0);
      ir_in = 1'b1; sir_en = 1'b1;
      repeat (100) step();
   endtask

   task automatic t_normal_tx();
      logic [6:0] pat = 7'b1101100; // sent LSB first: 0,0,1,1,0,1,1
      int h;
      lp_mode = 1'b0;
      align();
      for (int i = 0; i < 7; i++) begin
         send_bit(pat[i], h);
         if (i == 1) check(h == 3 * TP, "R4 second zero", h, 3 * TP);
         else check(h == (pat[i] ? 0 : 3 * TP), "R3 bit width", h, pat[i] ? 0 : 3 * TP);
      end
      uart_tx = 1'b1;
   endtask

   task automatic t_lowpower_tx();
      int h;
      lp_mode = 1'b1; psc = 8'd5;
      align();
      send_bit(1'b0, h);
      check(h == 15, "R5 lp width", h, 15);
      send_bit(1'b0, h);
      check(h == 15, "R5 lp repeat", h, 15);
      send_bit(1'b1, h);
      psc = 8'd0;
      align();
      send_bit(1'b0, h);
      check(h == 0, "R6 psc zero", h, 0);
      send_bit(1'b0, h);
      check(h == 0, "R6 psc zero repeat", h, 0);
      uart_tx = 1'b1; lp_mode = 1'b0;
      repeat (BIT) step();
   endtask

   task automatic pulse_in(input int width, input int total, output int lows, output int highs_after);
      lows = 0; highs_after = 0;
      ir_in = 1'b0;
      for (int i = 0; i < total; i++) begin
         if (i == width) ir_in = 1'b1;
         step();
         if (!uart_rx) lows++;
      end
   endtask

   task automatic t_normal_rx();
      int gaps = 0;
      lp_mode = 1'b0;
      align();
      // two zero bits back to back, 12-cycle pulses one bit apart
      for (int b = 0; b < 2; b++) begin
         ir_in = 1'b0;
         for (int i = 0; i < BIT; i++) begin
            if (i == 12) ir_in = 1'b1;
            step();
            if (!(b == 0 && i < 3) && uart_rx) gaps++;
         end
      end
      check(gaps == 0, "R7 no gap", gaps, 0);
      repeat (26) step();
      check(uart_rx == 1'b1, "R7 returns high", uart_rx, 1);
   endtask

   task automatic t_lowpower_rx();
      int lows, dummy, cnt;
      lp_mode = 1'b1; psc = 8'd4;
      repeat (4) step();
      pulse_in(3, 80, lows, dummy);
      check(lows == 0, "R8 glitch rejected", lows, 0);
      ir_in = 1'b0;
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
         if (i == 12) ir_in = 1'b1;
         step();
      end
      check(uart_rx == 1'b0, "R9 long low accepted", uart_rx, 0);
      repeat (90) step();
      check(uart_rx == 1'b1, "R9 returns high", uart_rx, 1);
      psc = 8'd0;
      repeat (4) step();
      pulse_in(12, 80, lows, dummy);
      check(lows == 0, "R10 psc zero rejects", lows, 0);
      lp_mode = 1'b0;
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      repeat (3) step();
      t_reset();
      t_bypass();
      t_normal_tx();
      t_lowpower_tx();
      t_normal_rx();
      t_lowpower_rx();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule